// File: doc/BRIEF.md
# CPU Condition Code Register Unit

This block keeps the 8-bit condition code register of a small 8-bit accumulator CPU. Each cycle it takes the outcome of the ALU: the result byte, the carry out of bit 7 and the carry out of bit 3. It also takes an operation class, explicit flag commands, interrupt entry and interrupt return. From these it forms the next register value. Each flag has its own update rule per operation class. The register changes on the rising clock edge that follows the inputs.

The bits of the register are C (bit 0), Z (bit 1), N (bit 2), I (bit 3), H (bit 4), and three upper bits that are always 1. The unit drives combinational branch conditions for each flag and for its inverse. It also gates interrupt requests with the I flag. A maskable request that arrives while I is set is held in a pending latch. It is granted as soon as I clears, and stays held until interrupt entry. The software trap is always granted.

Operation class encoding on `op_cls`: 0 = add / add-with-carry, 1 = logical or data move, 2 = shift or rotate, 3 = bit test and branch.

Top module: `ccr_unit`

## Requirements
- R1: Bits 7:5 of `ccr_q` always read 1, even after an interrupt return with `ret_val[7:5]` = 0.
- R2: While `rst_n` is low, and after reset, `ccr_q` is 0xE8 (I=1, other flags 0), and maskable requests are not granted.
- R3: When `alu_valid` is high with class 0, H takes `alu_c3`. Classes 1, 2 and 3 leave H unchanged.
- R4: With `alu_valid` high and class 0, 1 or 2, N takes `alu_res[7]` and Z is 1 exactly when `alu_res` is 0. Class 3 leaves N and Z unchanged.
- R5: With `alu_valid` high and class 0, 2 or 3, C takes `alu_c7`. Class 1 leaves C unchanged.
- R6: `cmd_scf` sets C and `cmd_rcf` clears C, overriding the ALU in the same cycle. When both are high, set wins.
- R7: `cmd_sim` sets I and `cmd_rim` clears I. When both are high, set wins.
- R8: `irq_enter` sets I and leaves H, N, Z and C unchanged. It has priority over interrupt return, over commands and over the ALU.
- R9: `irq_ret` loads bits 4:0 from `ret_val[4:0]`, including I. It has priority over commands and over the ALU.
- R10: `irq_take` is 1 whenever `trap_req` is 1. A maskable request (`irq_req` or a held pending request) asserts `irq_take` combinationally only while I is 0.
- R11: An `irq_req` pulse is held after it ends, so `irq_take` rises once I clears with no new request. `irq_enter` discards the held request.
- R12: `br_set[k]` equals `ccr_q[k]` and `br_clr[k]` equals its inverse, for k = 0 (C), 1 (Z), 2 (N), 3 (I), 4 (H).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alu_valid | input | 1 | ALU result applies this cycle |
| op_cls | input | 2 | Operation class (0 add, 1 logic/move, 2 shift/rotate, 3 bit test) |
| alu_res | input | 8 | ALU result byte |
| alu_c7 | input | 1 | Carry out of bit 7, shifted-out bit, or tested bit |
| alu_c3 | input | 1 | Carry from bit 3 into bit 4 |
| cmd_scf | input | 1 | Set carry |
| cmd_rcf | input | 1 | Clear carry |
| cmd_sim | input | 1 | Set interrupt mask |
| cmd_rim | input | 1 | Clear interrupt mask |
| irq_enter | input | 1 | Interrupt entry |
| irq_ret | input | 1 | Interrupt return |
| ret_val | input | 8 | Register value restored on return |
| irq_req | input | 1 | Maskable interrupt request |
| trap_req | input | 1 | Software trap request |
| ccr_q | output | 8 | Condition code register |
| br_set | output | 5 | Flag-is-set branch conditions |
| br_clr | output | 5 | Flag-is-clear branch conditions |
| irq_take | output | 1 | Interrupt grant |

## Verification
The bench walks through every operation class so that each flag is seen both written and kept. A unit that updated H on a shift, or C on a logical operation, would corrupt a flag the next branch still needs. It drives every conflict at once: entry together with return, commands and the ALU; set together with clear; commands against the ALU. A wrong priority would leave the mask clear on entry or let an ALU carry overwrite an explicit carry command. The interrupt tests pulse a request while masked and then unmask with no request present. A unit without the latch would lose that interrupt. A unit whose latch survives entry would grant the same interrupt twice.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

  localparam int CCR_W  = 8;
  localparam int FLAG_N = 5;

  localparam int IDX_C = 0;
  localparam int IDX_Z = 1;
  localparam int IDX_N = 2;
  localparam int IDX_I = 3;
  localparam int IDX_H = 4;

  localparam logic [CCR_W-FLAG_N-1:0] HI_ONES   = '1;
  localparam logic [FLAG_N-1:0]       FLAGS_RST = 5'b01000;

  typedef enum logic [1:0] {
    OPC_ARITH   = 2'd0,
    OPC_LOGIC   = 2'd1,
    OPC_SHIFT   = 2'd2,
    OPC_BITTEST = 2'd3
  } opc_e;

  typedef struct packed {
    logic set_c;
    logic clr_c;
    logic set_i;
    logic clr_i;
  } flag_cmd_t;

endpackage

// File: rtl/ccr_rst_sync.sv
module ccr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/ccr_flag_next.sv
module ccr_flag_next
  import ccr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [FLAG_N-1:0] flags_q,
  input  logic              alu_valid,
  input  opc_e              op,
  input  logic [DATA_W-1:0] alu_res,
  input  logic              alu_c7,
  input  logic              alu_c3,
  input  flag_cmd_t         cmd,
  input  logic              irq_enter,
  input  logic              irq_ret,
  input  logic [FLAG_N-1:0] ret_flags,
  output logic [FLAG_N-1:0] flags_d,
  output logic              upd_en
);

  localparam int MSB = DATA_W - 1;

  logic [FLAG_N-1:0] alu_f;
  logic [FLAG_N-1:0] cmd_f;
  logic              res_zero;
  logic              cmd_any;

  assign res_zero = (alu_res == '0);
  assign cmd_any  = cmd.set_c | cmd.clr_c | cmd.set_i | cmd.clr_i;

  // ALU-driven update, per class
  always_comb begin
    alu_f = flags_q;
    if (alu_valid) begin
      unique case (op)
        OPC_ARITH: begin
          alu_f[IDX_H] = alu_c3;
          alu_f[IDX_N] = alu_res[MSB];
          alu_f[IDX_Z] = res_zero;
          alu_f[IDX_C] = alu_c7;
        end
        OPC_LOGIC: begin
          alu_f[IDX_N] = alu_res[MSB];
          alu_f[IDX_Z] = res_zero;
        end
        OPC_SHIFT: begin
          alu_f[IDX_N] = alu_res[MSB];
          alu_f[IDX_Z] = res_zero;
          alu_f[IDX_C] = alu_c7;
        end
        OPC_BITTEST: begin
          alu_f[IDX_C] = alu_c7;
        end
        default: alu_f = flags_q;
      endcase
    end
  end

  // Explicit commands override the ALU, flag by flag
  always_comb begin
    cmd_f = alu_f;
    if (cmd.set_c) begin
      cmd_f[IDX_C] = 1'b1;
    end else if (cmd.clr_c) begin
      cmd_f[IDX_C] = 1'b0;
    end
    if (cmd.set_i) begin
      cmd_f[IDX_I] = 1'b1;
    end else if (cmd.clr_i) begin
      cmd_f[IDX_I] = 1'b0;
    end
  end

  // Entry > return > commands/ALU
  always_comb begin
    if (irq_enter) begin
      flags_d        = flags_q;
      flags_d[IDX_I] = 1'b1;
    end else if (irq_ret) begin
      flags_d = ret_flags;
    end else begin
      flags_d = cmd_f;
    end
  end

  assign upd_en = alu_valid | cmd_any | irq_enter | irq_ret;

endmodule

// File: rtl/ccr_irq_gate.sv
module ccr_irq_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic mask_q,
  input  logic irq_req,
  input  logic trap_req,
  input  logic irq_enter,
  output logic irq_take
);

  logic pend_q;
  logic pend_d;
  logic pend_en;

  always_comb begin
    pend_en = irq_req | irq_enter;
    pend_d  = irq_enter ? 1'b0 : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (pend_en) begin
      pend_q <= pend_d;
    end
  end

  assign irq_take = trap_req | (~mask_q & (irq_req | pend_q));

  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q && !trap_req) |-> !irq_take); // R10
  AST_TRAP_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> irq_take); // R10
  AST_PEND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(irq_req) && !$past(irq_enter) && !mask_q) |-> irq_take); // R11

endmodule

// File: rtl/ccr_branch.sv
module ccr_branch
  import ccr_pkg::*;
(
  input  logic [FLAG_N-1:0] flags_q,
  output logic [FLAG_N-1:0] br_set,
  output logic [FLAG_N-1:0] br_clr
);

  for (genvar k = 0; k < FLAG_N; k++) begin : g_cond
    assign br_set[k] = flags_q[k];
    assign br_clr[k] = ~flags_q[k];
  end

endmodule

// File: rtl/ccr_unit.sv
module ccr_unit
  import ccr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alu_valid,
  input  logic [1:0]        op_cls,
  input  logic [DATA_W-1:0] alu_res,
  input  logic              alu_c7,
  input  logic              alu_c3,
  input  logic              cmd_scf,
  input  logic              cmd_rcf,
  input  logic              cmd_sim,
  input  logic              cmd_rim,
  input  logic              irq_enter,
  input  logic              irq_ret,
  input  logic [CCR_W-1:0]  ret_val,
  input  logic              irq_req,
  input  logic              trap_req,
  output logic [CCR_W-1:0]  ccr_q,
  output logic [FLAG_N-1:0] br_set,
  output logic [FLAG_N-1:0] br_clr,
  output logic              irq_take
);

  logic              rst_sync_n;
  logic [FLAG_N-1:0] flags_q;
  logic [FLAG_N-1:0] flags_d;
  logic              upd_en;
  flag_cmd_t         cmd;
  opc_e              op;
  logic              unused_ret_hi;

  assign op            = opc_e'(op_cls);
  assign cmd           = '{set_c: cmd_scf, clr_c: cmd_rcf, set_i: cmd_sim, clr_i: cmd_rim};
  assign unused_ret_hi = ^ret_val[CCR_W-1:FLAG_N];

  ccr_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ccr_flag_next #(.DATA_W(DATA_W)) u_flag_next (
    .flags_q   (flags_q),
    .alu_valid (alu_valid),
    .op        (op),
    .alu_res   (alu_res),
    .alu_c7    (alu_c7),
    .alu_c3    (alu_c3),
    .cmd       (cmd),
    .irq_enter (irq_enter),
    .irq_ret   (irq_ret),
    .ret_flags (ret_val[FLAG_N-1:0]),
    .flags_d   (flags_d),
    .upd_en    (upd_en)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      flags_q <= FLAGS_RST;
    end else if (upd_en) begin
      flags_q <= flags_d;
    end
  end

  assign ccr_q = {HI_ONES, flags_q};

  ccr_irq_gate u_irq_gate (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .mask_q    (flags_q[IDX_I]),
    .irq_req   (irq_req),
    .trap_req  (trap_req),
    .irq_enter (irq_enter),
    .irq_take  (irq_take)
  );

  ccr_branch u_branch (
    .flags_q (flags_q),
    .br_set  (br_set),
    .br_clr  (br_clr)
  );

  AST_ENTRY_SETS_MASK: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_enter |=> ccr_q[IDX_I]); // R8
  AST_ENTRY_KEEPS_ALU_FLAGS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_enter |=> (ccr_q[IDX_H] == $past(ccr_q[IDX_H])) && (ccr_q[IDX_N:IDX_C] == $past(ccr_q[IDX_N:IDX_C]))); // R8
  AST_ARITH_HALF: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (alu_valid && op_cls == 2'd0 && !irq_enter && !irq_ret) |=> ccr_q[IDX_H] == $past(alu_c3)); // R3
  AST_HALF_KEPT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!(alu_valid && op_cls == 2'd0) && !irq_ret) |=> $stable(ccr_q[IDX_H])); // R3
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (alu_valid && op_cls != 2'd3 && !irq_enter && !irq_ret) |=> ccr_q[IDX_Z] == ($past(alu_res) == '0)); // R4
  AST_SCF_WINS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmd_scf && !irq_enter && !irq_ret) |=> ccr_q[IDX_C]); // R6
  AST_RET_LOADS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (irq_ret && !irq_enter) |=> ccr_q[FLAG_N-1:0] == $past(ret_val[FLAG_N-1:0])); // R9

endmodule

// File: tb/ccr_unit_bench.sv
module ccr_unit_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       alu_valid, alu_c7, alu_c3;
  logic [1:0] op_cls;
  logic [7:0] alu_res, ret_val;
  logic       cmd_scf, cmd_rcf, cmd_sim, cmd_rim;
  logic       irq_enter, irq_ret, irq_req, trap_req;
  logic [7:0] ccr_q;
  logic [4:0] br_set, br_clr;
  logic       irq_take;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ccr_unit u_ccr_unit (
    .clk(clk), .rst_n(rst_n), .alu_valid(alu_valid), .op_cls(op_cls),
    .alu_res(alu_res), .alu_c7(alu_c7), .alu_c3(alu_c3),
    .cmd_scf(cmd_scf), .cmd_rcf(cmd_rcf), .cmd_sim(cmd_sim), .cmd_rim(cmd_rim),
    .irq_enter(irq_enter), .irq_ret(irq_ret), .ret_val(ret_val),
    .irq_req(irq_req), .trap_req(trap_req),
    .ccr_q(ccr_q), .br_set(br_set), .br_clr(br_clr), .irq_take(irq_take)
  );

  // {valid, op[1:0], res[7:0], c7, c3, {scf,rcf,sim,rim}, expected ccr[7:0]}
  localparam int NV = 13;
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 2'd0, 8'h00, 1'b1, 1'b1, 4'b0000, 8'hFB}, // R3 R4 R5 add, zero
    {1'b1, 2'd1, 8'h80, 1'b0, 1'b0, 4'b0000, 8'hFD}, // R4 logic keeps H, C
    {1'b1, 2'd2, 8'h01, 1'b0, 1'b1, 4'b0000, 8'hF8}, // R5 shift, H kept
    {1'b1, 2'd3, 8'h00, 1'b1, 1'b0, 4'b0000, 8'hF9}, // R4 R5 bit test keeps N, Z
    {1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 4'b0001, 8'hF1}, // R7 clear mask
    {1'b1, 2'd0, 8'h7F, 1'b1, 1'b0, 4'b0100, 8'hE0}, // R6 clear carry beats ALU carry
    {1'b1, 2'd1, 8'h00, 1'b0, 1'b0, 4'b1000, 8'hE3}, // R6 set carry with logic
    {1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 4'b1100, 8'hE3}, // R6 set beats clear
    {1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 4'b0100, 8'hE2}, // R6 clear carry
    {1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 4'b0011, 8'hEA}, // R7 set beats clear
    {1'b1, 2'd2, 8'hFE, 1'b1, 1'b0, 4'b0001, 8'hE5}, // R4 R5 R7 shift negative
    {1'b1, 2'd3, 8'hFF, 1'b0, 1'b0, 4'b0000, 8'hE4}, // R5 bit test clears C
    {1'b1, 2'd0, 8'h10, 1'b0, 1'b1, 4'b0000, 8'hF0}  // R3 half carry
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_br(input string tag);
    chk({tag, " R12 br_set"}, {27'd0, br_set}, {27'd0, ccr_q[4:0]});
    chk({tag, " R12 br_clr"}, {27'd0, br_clr}, {27'd0, ~ccr_q[4:0]});
  endtask

  task automatic idle();
    alu_valid = 0; op_cls = 0; alu_res = 0; alu_c7 = 0; alu_c3 = 0;
    cmd_scf = 0; cmd_rcf = 0; cmd_sim = 0; cmd_rim = 0;
    irq_enter = 0; irq_ret = 0; ret_val = 0; irq_req = 0; trap_req = 0;
  endtask

  // Called at a falling edge; returns at the next falling edge with inputs idle.
  task automatic cyc();
    @(negedge clk);
    idle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 1'b0;
    irq_req = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2 ccr in reset", {24'd0, ccr_q}, 32'hE8);
    chk("R2 no grant in reset", {31'd0, irq_take}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R2 ccr after reset", {24'd0, ccr_q}, 32'hE8);
    chk("R2 masked after reset", {31'd0, irq_take}, 32'd0);
    chk_br("reset");
    irq_req = 1'b0;
    // clear request held during reset by entering once
    irq_enter = 1'b1;
    cyc();
    chk("R8 entry from reset", {24'd0, ccr_q}, 32'hE8);

    for (int i = 0; i < NV; i++) begin
      alu_valid = VEC[i][24];
      op_cls    = VEC[i][23:22];
      alu_res   = VEC[i][21:14];
      alu_c7    = VEC[i][13];
      alu_c3    = VEC[i][12];
      {cmd_scf, cmd_rcf, cmd_sim, cmd_rim} = VEC[i][11:8];
      cyc();
      chk($sformatf("vector %0d R3 R4 R5 R6 R7", i), {24'd0, ccr_q}, {24'd0, VEC[i][7:0]});
      chk_br($sformatf("vector %0d", i));
    end

    // R8: entry beats return, commands and ALU
    irq_enter = 1; irq_ret = 1; ret_val = 8'h00; cmd_rim = 1; cmd_scf = 1;
    alu_valid = 1; op_cls = 2'd0; alu_res = 8'h00; alu_c7 = 1;
    cyc();
    chk("R8 entry priority", {24'd0, ccr_q}, 32'hF8);

    // R9 R1: return beats commands and ALU, upper bits stay ones
    irq_ret = 1; ret_val = 8'h05; cmd_sim = 1; cmd_rcf = 1;
    alu_valid = 1; op_cls = 2'd1; alu_res = 8'h80;
    cyc();
    chk("R9 R1 return restore", {24'd0, ccr_q}, 32'hE5);
    chk_br("after return");

    // R10: unmasked request granted at once
    irq_req = 1;
    #1 chk("R10 unmasked grant", {31'd0, irq_take}, 32'd1);
    cyc();
    // R11: entry discards held request
    irq_enter = 1;
    cyc();
    chk("R8 entry sets mask", {24'd0, ccr_q}, 32'hED);
    cmd_rim = 1;
    cyc();
    chk("R7 mask cleared", {24'd0, ccr_q}, 32'hE5);
    chk("R11 entry discards held", {31'd0, irq_take}, 32'd0);
    cmd_sim = 1;
    cyc();
    // R10: request while masked blocked, then latched
    irq_req = 1;
    #1 chk("R10 masked request blocked", {31'd0, irq_take}, 32'd0);
    cyc();
    trap_req = 1;
    #1 chk("R10 trap while masked", {31'd0, irq_take}, 32'd1);
    trap_req = 0;
    #1 chk("R10 no trap masked", {31'd0, irq_take}, 32'd0);
    cmd_rim = 1;
    cyc();
    chk("R11 held request granted", {31'd0, irq_take}, 32'd1);
    irq_enter = 1;
    cyc();
    cmd_rim = 1;
    cyc();
    chk("R11 cleared after entry", {31'd0, irq_take}, 32'd0);
    chk("R7 final ccr", {24'd0, ccr_q}, 32'hE5);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule